// File: doc/BRIEF.md
# Eight-Channel Down-Counter Timer Bank

The block holds eight independent 32-bit countdown timers behind a simple memory-mapped register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. Each timer sits in its own 64-byte address window. The timer index is the address shifted right by six, and the register inside the window is the low six address bits. Each timer has the following state:

- a live count;
- a reload value;
- four control bits;
- an interrupt status flag;
- one interrupt line.

Software never writes the control bits directly. It writes ones to a set register or to a clear register instead. The clear register also acknowledges the interrupt status.

Each timer is a two-state machine. It is in `ST_IDLE` when disabled and in `ST_RUN` when counting, and control bit 0 shows whether it is in `ST_RUN`. The timer has three transitions:

- `GO`: `ST_IDLE` to `ST_RUN`, when a 1 is written to set-register bit 0.
- `HALT`: `ST_RUN` to `ST_IDLE`, when a 1 is written to clear-register bit 0.
- `DONE`: `ST_RUN` to `ST_IDLE`, when the timer expires in one-shot mode.

While in `ST_RUN`, the timer advances on every peripheral clock cycle, or only on cycles where the external 1 MHz strobe is high. When an advance finds the count already at zero, the timer expires. On expiry it raises its status flag. It then either reloads and carries on, or it stops.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, reload value, control bit and status flag is zero, and every `irq` bit is low.
- R2: The timer index is `bus_addr[8:6]` and the register is `bus_addr[5:0]`. Offset 0x00 is the count, which is read-only: writes to it are ignored. Offset 0x04 is the reload value, which is read/write. Offsets other than 0x00, 0x04, 0x10 and 0x14 read zero and ignore writes. `bus_rdata` is zero when `bus_re` is low.
- R3: Writing the reload register while the timer is in `ST_IDLE` also loads the count. The same write while in `ST_RUN` changes only the reload value.
- R4: At offset 0x10, each 1 in write-data bits [3:0] sets the matching control bit, and each 0 leaves its bit unchanged. A read of 0x10 returns the control bits in [3:0] and the status flag in bit 4. The control bits are: bit 0 run, bit 1 tick select (1 = 1 MHz strobe, 0 = peripheral clock), bit 2 interrupt enable, and bit 3 periodic (1 = periodic, 0 = one-shot).
- R5: At offset 0x14, each 1 in write-data bits [3:0] clears the matching control bit. Any 1 in those bits also clears the status flag, and this takes priority over an expiry in the same cycle. A write of all zeros has no effect. A read of 0x14 returns zero.
- R6: In `ST_RUN` with bit 1 clear, the count drops by one on every clock in which it is nonzero. In `ST_IDLE` the count holds.
- R7: In `ST_RUN` with bit 1 set, the count advances only on cycles where `tick_1us` is high.
- R8: An advance that finds the count at zero is an expiry, and it sets the status flag.
- R9: In periodic mode, an expiry loads the count from the reload value and the timer stays in `ST_RUN`. The period is therefore reload+1 advances.
- R10: In one-shot mode, an expiry leaves the count at zero and takes the `DONE` transition, so bit 0 reads 0.
- R11: `irq[i]` equals timer i's status flag ANDed with its control bit 2.
- R12: Timers are independent. Traffic to one timer's window leaves the other timers' registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address into the bank |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| tick_1us | input | 1 | External 1 MHz strobe, one clock wide |
| irq | output | 8 | Per-timer interrupt lines |

## Verification
The bench looks for the one-cycle edges of expiry, which are the most likely place for an off-by-one error:

- It samples a one-shot timer on the cycle where it holds zero and again on the cycle after. A design that fires on reaching zero rather than on the next advance, or that wraps to all ones, shows the flag early or a huge count.
- In periodic mode it checks that the count reloads exactly reload+1 cycles after starting. A timer that stalls at zero, or a reload that is one cycle late, misreads there.

The bench also probes the set/clear semantics:

- A zero write to either register must leave the bits alone. A design that assigns rather than merges would wipe the control field.
- A reload write during counting must not jump the count.
- The tick-select timer must hold its count while the strobe is low.

Finally, it reads undefined and misaligned offsets and the write-only clear register, expecting zero each time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned WIN_BITS = 6;     // 64-byte window per timer
    localparam int unsigned CTRL_W   = 4;

    // control bit positions
    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_TICK = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_PER  = 3;
    localparam int unsigned STAT_POS = 4;     // status position in read of set reg

    // register offsets inside a window
    localparam logic [WIN_BITS-1:0] OFS_COUNT  = 6'h00;
    localparam logic [WIN_BITS-1:0] OFS_RELOAD = 6'h04;
    localparam logic [WIN_BITS-1:0] OFS_SET    = 6'h10;
    localparam logic [WIN_BITS-1:0] OFS_CLR    = 6'h14;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_COUNT,
        RK_RELOAD,
        RK_SET,
        RK_CLR
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } tmr_state_e;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned N_TMR  = 8,
    parameter int unsigned ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_TMR-1:0]  sel,
    output reg_kind_e         kind
);
    localparam int unsigned IDX_W = ADDR_W - WIN_BITS;

    logic [IDX_W-1:0]    idx;
    logic [WIN_BITS-1:0] ofs;

    assign idx = addr[ADDR_W-1:WIN_BITS];
    assign ofs = addr[WIN_BITS-1:0];

    always_comb begin
        sel = '0;
        if (32'(idx) < N_TMR) begin
            sel[idx] = 1'b1;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_COUNT:  kind = RK_COUNT;
            OFS_RELOAD: kind = RK_RELOAD;
            OFS_SET:    kind = RK_SET;
            OFS_CLR:    kind = RK_CLR;
            default:    kind = RK_NONE;
        endcase
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  reg_kind_e         kind,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_1us,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    tmr_state_e        state_q, state_d;
    logic [3:1]        cfg_q;
    logic              status_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;

    logic rl_wr, set_wr, clr_wr, clr_any;
    logic running, tick_ok, expire;
    logic [CTRL_W-1:0] ctrl;

    assign rl_wr   = sel && wr_en && (kind == RK_RELOAD);
    assign set_wr  = sel && wr_en && (kind == RK_SET);
    assign clr_wr  = sel && wr_en && (kind == RK_CLR);
    assign clr_any = clr_wr && (wdata[CTRL_W-1:0] != '0);

    assign running = (state_q == ST_RUN);
    assign tick_ok = cfg_q[CB_TICK] ? tick_1us : 1'b1;
    assign expire  = running && tick_ok && (cnt_q == '0);
    assign ctrl    = {cfg_q, running};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state: GO, HALT, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (set_wr && wdata[CB_RUN]) state_d = ST_RUN;
            ST_RUN: begin
                if (clr_wr && wdata[CB_RUN])         state_d = ST_IDLE;
                else if (expire && !cfg_q[CB_PER])   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // configuration bits 3..1 and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            status_q <= 1'b0;
        end else begin
            if (set_wr) cfg_q <= cfg_q | wdata[3:1];
            else if (clr_wr) cfg_q <= cfg_q & ~wdata[3:1];
            if (clr_any)     status_q <= 1'b0;
            else if (expire) status_q <= 1'b1;
        end
    end

    // count and reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else begin
            if (rl_wr) reload_q <= wdata;
            if (running && tick_ok) begin
                if (cnt_q == '0) cnt_q <= cfg_q[CB_PER] ? reload_q : '0;
                else             cnt_q <= cnt_q - ONE;
            end else if (!running && rl_wr) begin
                cnt_q <= wdata;
            end
        end
    end

    // outputs
    always_comb begin
        rdata = '0;
        if (sel && rd_en) begin
            unique case (kind)
                RK_COUNT:  rdata = cnt_q;
                RK_RELOAD: rdata = reload_q;
                RK_SET: begin
                    rdata[CTRL_W-1:0] = ctrl;
                    rdata[STAT_POS]   = status_q;
                end
                default:   rdata = '0;
            endcase
        end
        irq = status_q && cfg_q[CB_IRQ];
    end

    // R6: nonzero count drops by exactly one per advance
    p_dec_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_ok && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: tick mode holds without strobe
    p_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_q[CB_TICK] && !tick_1us) |=> $stable(cnt_q));

    // R8: expiry raises status unless acknowledged in the same cycle
    p_expire_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clr_any) |=> status_q);

    // R9: periodic expiry reloads and keeps running
    p_periodic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg_q[CB_PER] && !clr_wr) |=> (cnt_q == $past(reload_q) && state_q == ST_RUN));

    // R10: one-shot expiry stops at zero
    p_oneshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cfg_q[CB_PER]) |=> (state_q == ST_IDLE && cnt_q == '0));

    // R3: idle count changes only through a reload write
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rl_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned N_TMR  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = $clog2(N_TMR) + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_1us,
    output logic [N_TMR-1:0]  irq
);
    logic [N_TMR-1:0]  sel;
    reg_kind_e         kind;
    logic [DATA_W-1:0] rd_each [N_TMR];

    tmr_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .kind (kind)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel[i]),
            .kind     (kind),
            .wr_en    (bus_we),
            .rd_en    (bus_re),
            .wdata    (bus_wdata),
            .tick_1us (tick_1us),
            .rdata    (rd_each[i]),
            .irq      (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            bus_rdata = bus_rdata | rd_each[i];
        end
    end

    // R2: nothing is driven onto read data without a read strobe
    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_1us = 1'b0;
    logic [7:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .tick_1us(tick_1us), .irq(irq)
    );

    function automatic logic [8:0] ad(input int t, input int r);
        return 9'((t << 6) | r);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // drive at negedge, captured at next posedge, returns at following negedge
    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata;
        bus_re = 1'b0;
        #1;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int t = 0; t < 8; t++) begin
            rd(ad(t, 6'h00), v); check("R1 count", v, 0);
            rd(ad(t, 6'h04), v); check("R1 reload", v, 0);
            rd(ad(t, 6'h10), v); check("R1 ctrl", v, 0);
        end
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(ad(1, 6'h08), 32'hDEAD_BEEF);
        rd(ad(1, 6'h08), v); check("R2 undefined offset", v, 0);
        rd(ad(1, 6'h02), v); check("R2 misaligned offset", v, 0);
        wr(ad(1, 6'h00), 32'h55);
        rd(ad(1, 6'h00), v); check("R2 count read-only", v, 0);
        wr(ad(1, 6'h04), 32'h1234);
        rd(ad(1, 6'h04), v); check("R2 reload readback", v, 32'h1234);
        rd(ad(1, 6'h00), v); check("R3 idle reload loads count", v, 32'h1234);
        rd(ad(1, 6'h14), v); check("R5 clear reg reads zero", v, 0);
        rd(ad(5, 6'h04), v); check("R12 other reload untouched", v, 0);
        rd(ad(0, 6'h00), v); check("R12 other count untouched", v, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(ad(0, 6'h04), 32'd10);
        rd(ad(0, 6'h00), v); check("R3 count loaded", v, 10);
        wr(ad(0, 6'h10), 32'h1);
        rd(ad(0, 6'h00), v); check("R6 count before first advance", v, 10);
        wait_cyc(3);
        rd(ad(0, 6'h00), v); check("R6 decrement per clock", v, 7);
        rd(ad(1, 6'h00), v); check("R12 idle neighbour holds", v, 32'h1234);
        wait_cyc(7);
        rd(ad(0, 6'h00), v); check("R8 count at zero", v, 0);
        rd(ad(0, 6'h10), v); check("R8 no flag before expiry", v, 32'h1);
        wait_cyc(1);
        rd(ad(0, 6'h10), v); check("R10 one-shot stops, R8 flag", v, 32'h10);
        rd(ad(0, 6'h00), v); check("R10 count stays zero", v, 0);
        wait_cyc(2);
        rd(ad(0, 6'h00), v); check("R10 still zero", v, 0);
        check("R11 irq off without enable", 32'(irq[0]), 0);
        wr(ad(0, 6'h04), 32'd4);
        rd(ad(0, 6'h00), v); check("R3 reload after stop", v, 4);
        wr(ad(0, 6'h10), 32'h1);
        wr(ad(0, 6'h04), 32'd50);
        rd(ad(0, 6'h00), v); check("R3 running reload no jump", v, 3);
        rd(ad(0, 6'h04), v); check("R3 reload value taken", v, 50);
        wr(ad(0, 6'h14), 32'hF);
        rd(ad(0, 6'h10), v); check("R5 clear all", v, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(ad(2, 6'h04), 32'd3);
        wr(ad(2, 6'h10), 32'h9);
        wait_cyc(3);
        rd(ad(2, 6'h00), v); check("R9 reaches zero", v, 0);
        rd(ad(2, 6'h10), v); check("R9 no flag yet", v, 32'h9);
        wait_cyc(1);
        rd(ad(2, 6'h00), v); check("R9 reload on expiry", v, 3);
        rd(ad(2, 6'h10), v); check("R9 still running, flag set", v, 32'h19);
        check("R11 irq masked", 32'(irq[2]), 0);
        wait_cyc(1);
        rd(ad(2, 6'h00), v); check("R9 continues", v, 2);
        wr(ad(2, 6'h10), 32'h4);
        check("R11 irq asserted", 32'(irq[2]), 1);
        check("R12 only own irq", 32'(irq & 8'hFB), 0);
        wr(ad(2, 6'h14), 32'hF);
        check("R11 irq dropped after clear", 32'(irq[2]), 0);
        rd(ad(2, 6'h10), v); check("R5 status cleared", v, 0);
    endtask

    task automatic t_tick;
        logic [31:0] v;
        wr(ad(6, 6'h04), 32'd5);
        wr(ad(6, 6'h10), 32'h3);
        wait_cyc(4);
        rd(ad(6, 6'h00), v); check("R7 holds without strobe", v, 5);
        tick_1us = 1'b1; @(negedge clk); tick_1us = 1'b0;
        rd(ad(6, 6'h00), v); check("R7 one advance per strobe", v, 4);
        wait_cyc(3);
        tick_1us = 1'b1; @(negedge clk); tick_1us = 1'b0;
        rd(ad(6, 6'h00), v); check("R7 second strobe", v, 3);
        wr(ad(6, 6'h14), 32'hF);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(ad(3, 6'h10), 32'hE);
        rd(ad(3, 6'h10), v); check("R4 set bits", v, 32'hE);
        wr(ad(3, 6'h14), 32'h4);
        rd(ad(3, 6'h10), v); check("R5 clear one bit", v, 32'hA);
        wr(ad(3, 6'h10), 32'h0);
        rd(ad(3, 6'h10), v); check("R4 zero set no change", v, 32'hA);
        wr(ad(3, 6'h14), 32'h2);
        wr(ad(3, 6'h10), 32'h1);
        wait_cyc(1);
        rd(ad(3, 6'h10), v); check("R8 periodic reload zero flag", v, 32'h19);
        wr(ad(3, 6'h14), 32'h0);
        rd(ad(3, 6'h10), v); check("R5 zero clear no effect", v, 32'h19);
        wr(ad(3, 6'h14), 32'h1);
        rd(ad(3, 6'h10), v); check("R5 clear wins over expiry", v, 32'h8);
    endtask

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_map();
        t_oneshot();
        t_periodic();
        t_tick();
        t_setclr();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule